// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the machine-mode trigger registers of a small 32-bit core's debug unit. A trigger index register chooses one of the hardware triggers. Three data windows then reach that trigger: a control word, a compare value, and an auxiliary word. A read-only capability word tells software which match kinds the triggers support. The core's CSR unit drives an address, a write strobe and write data. It gets read data back in the same cycle, along with a flag that says whether this block owns the address.

Control-word writes pass through a legalizer before they are stored. The kind field cannot change. The debug-ownership bit always reads as zero. Match, chain, action, timing, select and hit always read as zero. Only the privilege enables, the load/store/execute enables and a legal access size are kept. Each trigger's stored control word and compare value go out on flat buses to the address-match logic.

A parameter sets the match kind of every trigger for a given build: kind 2 by default, or kind 6. The CSR port is a plain register port with no back-pressure. A write is taken on the clock edge where the strobe is high, and the read data follow the address combinationally.

Top module: `dbg_trig_bank`

## Requirements
- R1: After reset the index register is 0. Every trigger's control word holds only its kind in bits 31:28 (0x2000_0000 for kind 2, 0x6000_0000 for kind 6), and every compare value is 0.
- R2: A write to address 0x7A0 loads the index register only when the full 32-bit write value is below the trigger count. Otherwise the old index is kept. A read of 0x7A0 returns the index.
- R3: Bits 31:28 of a stored control word always hold the build's kind, whatever value was written there.
- R4: Bit 27 (debug ownership) of a stored control word always reads 0.
- R5: A write to 0x7A1 stores into the selected trigger only a fixed set of bits. For kind 2 these are bits 0, 1, 2 (load, store, execute), bits 3, 4, 6 (user, supervisor, machine) and the size field in bits 17:16. For kind 6 they are bits 0 to 4 and bit 6 as for kind 2, plus the virtual-mode enables in bits 23 and 24, plus the size field in bits 19:16. All other bits read 0.
- R6: Kind 6 keeps a size code only if it is 0, 1, 2, 3 or 5 (any, 1, 2, 4, 8 bytes). Any other code leaves the size field at 0. For kind 2, all four codes of the 2-bit field are kept.
- R7: A write to 0x7A2 stores all 32 bits as the selected trigger's compare value. A read of 0x7A2 returns it, and a read of 0x7A1 returns the selected control word.
- R8: Address 0x7A3 always reads 0, and writes to it change no state.
- R9: Address 0x7A4 reads 0x0000_0044 (bits 2 and 6 set), and writes to it change no state.
- R10: Addresses 0x7A0 to 0x7A4 raise csr_hit. Any other address reads 0, drops csr_hit, and its writes change no state.
- R11: Data writes reach only the trigger chosen by the index. Trigger i's words appear at bits i*32 and up of trig_ctrl and trig_cmp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write strobe, taken on the rising edge |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for csr_addr, combinational |
| csr_hit | output | 1 | Address belongs to this bank |
| trig_ctrl | output | NTRIG*32 | Stored control words, trigger i at bits i*32 and up |
| trig_cmp | output | NTRIG*32 | Stored compare values, trigger i at bits i*32 and up |

## Verification
The hardest path to reach is the size fallback. With the default kind-2 build every 2-bit size code is legal, so the fallback cannot occur at all. The bench therefore runs a second, kind-6 instance in parallel on the same stimulus, and drives it with directed size codes 4, 6 and 15 as well as random control words. A second awkward case is an index write with a large value whose low bit alone would select a valid trigger. The random index writes mix full 32-bit values with small values, including the trigger count itself.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  localparam logic [11:0] ADDR_INDEX = 12'h7A0;
  localparam logic [11:0] ADDR_CTRL  = 12'h7A1;
  localparam logic [11:0] ADDR_CMP   = 12'h7A2;
  localparam logic [11:0] ADDR_AUX   = 12'h7A3;
  localparam logic [11:0] ADDR_CAPS  = 12'h7A4;

  // bits kept on a control write, per match kind (size handled apart for kind 6)
  localparam logic [31:0] KEEP_K2      = 32'h0003_005F;
  localparam logic [31:0] KEEP_K6      = 32'h0180_005F;
  localparam logic [31:0] SIZE_K6_MASK = 32'h000F_0000;
  localparam int          SIZE_K6_LSB  = 16;
  localparam logic [31:0] CAPS_VALUE   = 32'h0000_0044;

  typedef enum logic [2:0] {
    WIN_INDEX, WIN_CTRL, WIN_CMP, WIN_AUX, WIN_CAPS, WIN_NONE
  } win_e;

endpackage

// File: rtl/dbg_trig_decode.sv
module dbg_trig_decode
  import dbg_trig_pkg::*;
(
  input  logic [11:0] addr,
  output win_e        win,
  output logic        hit
);
  always_comb begin
    unique case (addr)
      ADDR_INDEX: win = WIN_INDEX;
      ADDR_CTRL:  win = WIN_CTRL;
      ADDR_CMP:   win = WIN_CMP;
      ADDR_AUX:   win = WIN_AUX;
      ADDR_CAPS:  win = WIN_CAPS;
      default:    win = WIN_NONE;
    endcase
    hit = (win != WIN_NONE);
  end
endmodule

// File: rtl/dbg_trig_legal.sv
module dbg_trig_legal
  import dbg_trig_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MTYPE = 2
) (
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] legal
);
  localparam int TYPE_LSB = XLEN - 4;
  localparam logic [XLEN-1:0] KIND_BITS = XLEN'(MTYPE) << TYPE_LSB;

  generate
    if (MTYPE == 6) begin : g_kind6
      logic [3:0] size_code;
      logic       size_ok;
      always_comb begin
        size_code = 4'((wdata & XLEN'(SIZE_K6_MASK)) >> SIZE_K6_LSB);
        unique case (size_code)
          4'd0, 4'd1, 4'd2, 4'd3, 4'd5: size_ok = 1'b1;
          default:                      size_ok = 1'b0;
        endcase
        legal = KIND_BITS | (wdata & XLEN'(KEEP_K6));
        if (size_ok) legal = legal | (wdata & XLEN'(SIZE_K6_MASK));
      end
    end else begin : g_kind2
      assign legal = KIND_BITS | (wdata & XLEN'(KEEP_K2));
    end
  endgenerate
endmodule

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot #(
  parameter int XLEN  = 32,
  parameter int MTYPE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            cmp_we,
  input  logic [XLEN-1:0] ctrl_new,
  input  logic [XLEN-1:0] cmp_new,
  output logic [XLEN-1:0] ctrl_q,
  output logic [XLEN-1:0] cmp_q
);
  localparam int TYPE_LSB = XLEN - 4;
  localparam logic [XLEN-1:0] CTRL_RESET = XLEN'(MTYPE) << TYPE_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      cmp_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_new;
      if (cmp_we)  cmp_q  <= cmp_new;
    end
  end
endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
  import dbg_trig_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NTRIG = 2,
  parameter int MTYPE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [11:0]           csr_addr,
  input  logic                  csr_we,
  input  logic [XLEN-1:0]       csr_wdata,
  output logic [XLEN-1:0]       csr_rdata,
  output logic                  csr_hit,
  output logic [NTRIG*XLEN-1:0] trig_ctrl,
  output logic [NTRIG*XLEN-1:0] trig_cmp
);
  localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

  win_e             win;
  logic [SEL_W-1:0] sel_q;
  logic [XLEN-1:0]  ctrl_legal;
  logic [XLEN-1:0]  ctrl_arr [NTRIG];
  logic [XLEN-1:0]  cmp_arr  [NTRIG];

  dbg_trig_decode u_dec (
    .addr (csr_addr),
    .win  (win),
    .hit  (csr_hit)
  );

  dbg_trig_legal #(.XLEN(XLEN), .MTYPE(MTYPE)) u_legal (
    .wdata (csr_wdata),
    .legal (ctrl_legal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (csr_we && win == WIN_INDEX && csr_wdata < XLEN'(NTRIG)) begin
      sel_q <= SEL_W'(csr_wdata);
    end
  end

  generate
    for (genvar i = 0; i < NTRIG; i++) begin : g_slot
      logic this_sel;
      assign this_sel = (sel_q == SEL_W'(i));

      dbg_trig_slot #(.XLEN(XLEN), .MTYPE(MTYPE)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (csr_we && this_sel && win == WIN_CTRL),
        .cmp_we   (csr_we && this_sel && win == WIN_CMP),
        .ctrl_new (ctrl_legal),
        .cmp_new  (csr_wdata),
        .ctrl_q   (ctrl_arr[i]),
        .cmp_q    (cmp_arr[i])
      );

      assign trig_ctrl[i*XLEN +: XLEN] = ctrl_arr[i];
      assign trig_cmp[i*XLEN +: XLEN]  = cmp_arr[i];
    end
  endgenerate

  always_comb begin
    unique case (win)
      WIN_INDEX: csr_rdata = XLEN'(sel_q);
      WIN_CTRL:  csr_rdata = ctrl_arr[sel_q];
      WIN_CMP:   csr_rdata = cmp_arr[sel_q];
      WIN_CAPS:  csr_rdata = XLEN'(CAPS_VALUE);
      default:   csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_trig_bank_chk.sv
module dbg_trig_bank_chk
  import dbg_trig_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NTRIG = 2,
  parameter int MTYPE = 2,
  parameter int SEL_W = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [11:0]           csr_addr,
  input logic                  csr_we,
  input logic [XLEN-1:0]       csr_wdata,
  input logic [XLEN-1:0]       csr_rdata,
  input logic                  csr_hit,
  input logic [NTRIG*XLEN-1:0] trig_ctrl,
  input logic [NTRIG*XLEN-1:0] trig_cmp,
  input logic [SEL_W-1:0]      sel_q
);
  a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) < NTRIG);

  a_r2_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == ADDR_INDEX && csr_wdata >= XLEN'(NTRIG)) |=> $stable(sel_q));

  a_r7_cmp_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && csr_addr == ADDR_CMP) |=> $stable(trig_cmp));

  a_r8_aux_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_AUX) |-> (csr_hit && csr_rdata == '0));

  a_r9_caps_value: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_CAPS) |-> (csr_rdata == XLEN'(CAPS_VALUE)));

  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_hit |-> (csr_rdata == '0));

  generate
    for (genvar i = 0; i < NTRIG; i++) begin : g_trig
      a_r3_kind_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ctrl[i*XLEN + XLEN-4 +: 4] == 4'(MTYPE));
      a_r4_owner_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ctrl[i*XLEN + XLEN-5] == 1'b0);
    end
  endgenerate
endmodule

bind dbg_trig_bank dbg_trig_bank_chk #(
  .XLEN(XLEN), .NTRIG(NTRIG), .MTYPE(MTYPE), .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_addr  (csr_addr),
  .csr_we    (csr_we),
  .csr_wdata (csr_wdata),
  .csr_rdata (csr_rdata),
  .csr_hit   (csr_hit),
  .trig_ctrl (trig_ctrl),
  .trig_cmp  (trig_cmp),
  .sel_q     (sel_q)
);

// File: tb/tb_dbg_trig_bank.sv
module tb_dbg_trig_bank;
  localparam int NT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = 12'h000;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;

  logic [31:0]      rd2, rd6;
  logic             hit2, hit6;
  logic [NT*32-1:0] ctrl2, cmp2, ctrl6, cmp6;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] m_ctrl2 [NT];
  logic [31:0] m_ctrl6 [NT];
  logic [31:0] m_cmp   [NT];
  int          m_sel;

  always #2 clk = ~clk;

  dbg_trig_bank #(.NTRIG(NT), .MTYPE(2)) dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(rd2), .csr_hit(hit2),
    .trig_ctrl(ctrl2), .trig_cmp(cmp2)
  );

  dbg_trig_bank #(.NTRIG(NT), .MTYPE(6)) dut6 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(rd6), .csr_hit(hit6),
    .trig_ctrl(ctrl6), .trig_cmp(cmp6)
  );

  function automatic logic [31:0] legal(input logic [31:0] w, input int kind);
    logic [31:0] v;
    if (kind == 2) return 32'h2000_0000 | (w & 32'h0003_005F);
    v = 32'h6000_0000 | (w & 32'h0180_005F);
    if (w[19:16] inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5}) v[19:16] = w[19:16];
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    case (a)
      12'h7A0: if (d < 32'(NT)) m_sel = int'(d);
      12'h7A1: begin
        m_ctrl2[m_sel] = legal(d, 2);
        m_ctrl6[m_sel] = legal(d, 6);
      end
      12'h7A2: m_cmp[m_sel] = d;
      default: ;
    endcase
  endtask

  task automatic csr_rd(input string req, input logic [11:0] a,
                        input logic [31:0] e2, input logic [31:0] e6, input logic eh);
    csr_addr = a; csr_we = 1'b0;
    #1;
    chk(req, "rdata k2", rd2, e2);
    chk(req, "rdata k6", rd6, e6);
    chk(req, "hit", {31'd0, hit2 & hit6}, {31'd0, eh});
  endtask

  task automatic check_state(input string req);
    #1;
    for (int i = 0; i < NT; i++) begin
      chk(req, $sformatf("ctrl%0d k2", i), ctrl2[i*32 +: 32], m_ctrl2[i]);
      chk(req, $sformatf("ctrl%0d k6", i), ctrl6[i*32 +: 32], m_ctrl6[i]);
      chk(req, $sformatf("cmp%0d k2", i),  cmp2[i*32 +: 32],  m_cmp[i]);
      chk(req, $sformatf("cmp%0d k6", i),  cmp6[i*32 +: 32],  m_cmp[i]);
    end
    csr_rd(req, 12'h7A0, 32'(m_sel), 32'(m_sel), 1'b1);
    csr_rd(req, 12'h7A1, m_ctrl2[m_sel], m_ctrl6[m_sel], 1'b1);
    csr_rd(req, 12'h7A2, m_cmp[m_sel], m_cmp[m_sel], 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [11:0] a;
    void'($urandom(32'd5150));
    for (int i = 0; i < NT; i++) begin
      m_ctrl2[i] = 32'h2000_0000; m_ctrl6[i] = 32'h6000_0000; m_cmp[i] = '0;
    end
    m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_state("R1");

    // R2 index writes
    csr_wr(12'h7A0, 32'd1);          check_state("R2");
    csr_wr(12'h7A0, 32'd2);          check_state("R2");
    csr_wr(12'h7A0, 32'hFFFF_FFFF);  check_state("R2");
    csr_wr(12'h7A0, 32'h0000_0003);  check_state("R2");
    csr_wr(12'h7A0, 32'd0);          check_state("R2");

    // R3 R4 R5: all ones into trigger 0
    csr_wr(12'h7A1, 32'hFFFF_FFFF);
    chk("R3", "kind k2", {28'd0, ctrl2[31:28]}, 32'd2);
    chk("R4", "owner k6", {31'd0, ctrl6[27]}, 32'd0);
    chk("R5", "ctrl k2", ctrl2[31:0], 32'h2003_005F);
    chk("R5", "ctrl k6 size15", ctrl6[31:0], 32'h6180_005F);
    csr_wr(12'h7A1, 32'h6800_0000);
    chk("R3", "kind change k2", ctrl2[31:0], 32'h2000_0000);

    // R6 size codes
    csr_wr(12'h7A1, 32'h0005_0004); chk("R6", "size5 k6", ctrl6[31:0], 32'h6005_0004);
    chk("R6", "size k2", ctrl2[31:0], 32'h2001_0004);
    csr_wr(12'h7A1, 32'h0004_0001); chk("R6", "size4 k6", ctrl6[31:0], 32'h6000_0001);
    csr_wr(12'h7A1, 32'h0006_0002); chk("R6", "size6 k6", ctrl6[31:0], 32'h6000_0002);
    csr_wr(12'h7A1, 32'h0003_0000); chk("R6", "size3 k6", ctrl6[31:0], 32'h6003_0000);
    chk("R6", "size3 k2", ctrl2[31:0], 32'h2003_0000);
    check_state("R6");

    // R7 R11 compare on trigger 1 only
    csr_wr(12'h7A0, 32'd1);
    csr_wr(12'h7A2, 32'hDEAD_BEEF);
    chk("R11", "cmp0 untouched", cmp2[31:0], 32'h0);
    chk("R7", "cmp1", cmp2[63:32], 32'hDEAD_BEEF);
    check_state("R7");

    // R8 aux window
    csr_wr(12'h7A3, 32'h1234_5678);
    check_state("R8");
    csr_rd("R8", 12'h7A3, 32'h0, 32'h0, 1'b1);

    // R9 capability word
    csr_rd("R9", 12'h7A4, 32'h44, 32'h44, 1'b1);
    csr_wr(12'h7A4, 32'hFFFF_FFFF);
    csr_rd("R9", 12'h7A4, 32'h44, 32'h44, 1'b1);
    check_state("R9");

    // R10 unmapped
    csr_rd("R10", 12'h7A5, 32'h0, 32'h0, 1'b0);
    csr_rd("R10", 12'h79F, 32'h0, 32'h0, 1'b0);
    csr_wr(12'h7A5, 32'hFFFF_FFFF);
    csr_wr(12'h3A1, 32'hFFFF_FFFF);
    check_state("R10");

    // random mix
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 7)
        0: begin
          d = ($urandom % 4 == 0) ? $urandom : 32'($urandom % 3);
          csr_wr(12'h7A0, d);
        end
        1, 2: csr_wr(12'h7A1, $urandom);
        3: csr_wr(12'h7A2, $urandom);
        4: csr_wr(12'h7A3, $urandom);
        5: csr_wr(12'h7A4, $urandom);
        default: begin
          a = 12'($urandom);
          if (a >= 12'h7A0 && a <= 12'h7A4) a = 12'h123;
          csr_wr(a, $urandom);
          csr_rd("R10", a, 32'h0, 32'h0, 1'b0);
        end
      endcase
      check_state("R11");
    end

    finish_run();
  end
endmodule